// File: doc/BRIEF.md
# Slot-Addressed Bus Slave Decoder

This block is the slave-side front end of a readout board on a backplane bus. The board's crate slot is strapped onto six input pins and read once after reset. An address from the master belongs to the board when address bits 21 to 16 equal that slot and every bit above them is zero. The 64 KB window that results is split into eight 8 KB regions. For an accepted beat the block raises exactly one region select for one cycle, together with the word offset and a write strobe. It then returns an acknowledge that carries the read data of that region.

The block also checks that each cycle is allowed. Cycles outside the 32-bit address space and addresses outside the window get no response at all. In-window cycles that are narrower than a word, misaligned, aimed at a reserved region, writes to the identification region, or block transfers to the control region get a bus error instead of an acknowledge. During a block transfer the block keeps its own word address and steps it by 4 bytes per beat. A beat that would leave the starting region ends the burst with an error.

Top module: `slot_bus_decoder`

## Requirements
- R1: A beat is claimed only when address bits 21:16 equal the sampled slot number and address bits 31:22 are all zero. Any other address gets neither acknowledge nor error, and no region select.
- R2: When `a32_cyc` is low, the cycle is ignored: no select, no acknowledge, no error.
- R3: Address bits 15:13 choose the region, and `region_sel[k]` is high for region k. The live regions are: 0 identification, 1 control/status, 2 test memory, 3 serial command, 4 serial readback, 5 event buffer. During the select cycle, `reg_addr` carries address bits 12:0 with bits 1:0 cleared, and `reg_wr` follows the master's write flag. At most one select is ever high.
- R4: The select is high for exactly one cycle, starting one clock edge after the strobe is sampled. The acknowledge rises one edge later. On a read, `rdata` then carries the word the selected region offered during the select cycle. The acknowledge or error stays high while the strobe is held and drops one edge after the strobe is released.
- R5: An in-window beat with `word_cyc` low, or with address bits 1:0 not zero, gets a bus error one edge after the strobe is sampled, and raises no select. Acknowledge and error are never high together.
- R6: Regions 6 and 7 (offsets 0xC000 to 0xFFFF) are reserved. Beats that decode to them get a bus error and raise no select.
- R7: A write to region 0 gets a bus error and raises no select. Reads of region 0 are acknowledged.
- R8: A block-transfer beat (`blk_cyc` high) aimed at region 1 gets a bus error, as do all later beats of that burst. Single-beat reads and writes to region 1 are acknowledged.
- R9: While `blk_cyc` stays high, the first beat fixes the region and offset. Each later beat uses the previous offset plus 4 and ignores the bus address, including its slot bits. Dropping `blk_cyc` for one idle cycle ends the burst.
- R10: A burst beat whose stepped offset would pass the end of its 8 KB region gets a bus error, and so does every later beat until the burst ends. A new access after the burst ends is served normally.
- R11: The slot strap is sampled on the first clock edge after reset. Later changes on `slot_id` do not move the window.
- R12: Out of reset, all selects, `reg_wr`, `ack`, `berr` and `rdata` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_id | input | 6 | Strapped crate slot number |
| strb | input | 1 | Master data strobe, held for one beat |
| a32_cyc | input | 1 | Cycle is in the 32-bit address space |
| word_cyc | input | 1 | Cycle moves a full 32-bit word |
| blk_cyc | input | 1 | Block transfer in progress |
| wr | input | 1 | Write when high, read when low |
| bus_addr | input | 32 | Byte address from the master |
| bus_wdata | input | 32 | Write data from the master |
| region_rdata | input | 256 | Read data offered by each region, region k at bits 32k+31:32k |
| region_sel | output | 8 | One-hot region select, high for one cycle |
| reg_addr | output | 13 | Byte offset inside the selected region |
| reg_wr | output | 1 | Write strobe qualifying the select |
| reg_wdata | output | 32 | Write data toward the regions |
| ack | output | 1 | Beat acknowledge |
| berr | output | 1 | Beat error response |
| rdata | output | 32 | Read data, valid with the acknowledge |

## Verification
The decoder is driven with single beats that reach every live region, with both reads and writes, at offsets that include the last word of a region. Each acknowledged beat is checked for the right select, offset and returned word, which shows that region bits and offset bits are not mixed up. Some beats must be refused: bad address spaces, slot or upper-bit mismatches, narrow or misaligned cycles, reserved regions, writes to the identification region and control-region bursts. These show whether a rule leads to silence or to a bus error. Burst runs fed with garbage addresses after the first beat, and a run started two words before a region end, separate the block's own increment from the master's address and show where the burst is cut off.

// File: rtl/slot_bus_decoder.sv
module slot_bus_decoder #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int SLOT_W   = 6,
  parameter int REG_AW   = 13,
  parameter int REG_CNT  = 8,
  parameter int LIVE_CNT = 6,
  parameter int ID_REG   = 0,
  parameter int CSR_REG  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SLOT_W-1:0]     slot_id,
  input  logic                  strb,
  input  logic                  a32_cyc,
  input  logic                  word_cyc,
  input  logic                  blk_cyc,
  input  logic                  wr,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  input  logic [REG_CNT*DW-1:0] region_rdata,
  output logic [REG_CNT-1:0]    region_sel,
  output logic [REG_AW-1:0]     reg_addr,
  output logic                  reg_wr,
  output logic [DW-1:0]         reg_wdata,
  output logic                  ack,
  output logic                  berr,
  output logic [DW-1:0]         rdata
);
  localparam int SEL_W    = $clog2(REG_CNT);
  localparam int SLOT_LSB = REG_AW + SEL_W;
  localparam int SLOT_MSB = SLOT_LSB + SLOT_W - 1;
  localparam int WORD_W   = REG_AW - 2;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_DONE} st_t;
  st_t st;

  logic [SLOT_W-1:0] slot_q;
  logic              slot_vld;
  logic              bst_act, bst_bad, bst_wrap;
  logic [SEL_W-1:0]  bst_reg, reg_q, cur_reg;
  logic [WORD_W-1:0] bst_off, off_q, cur_off;
  logic [WORD_W:0]   nxt_off;
  logic              wr_q, ack_q, berr_q;
  logic [DW-1:0]     rdata_q;
  logic              cont, slot_hit, hit, bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_vld <= 1'b0;
      slot_q   <= '0;
    end else if (!slot_vld) begin
      slot_vld <= 1'b1;
      slot_q   <= slot_id;
    end
  end

  assign cont     = bst_act && blk_cyc;
  assign cur_reg  = cont ? bst_reg : bus_addr[SLOT_LSB-1:REG_AW];
  assign cur_off  = cont ? bst_off : bus_addr[REG_AW-1:2];
  assign nxt_off  = {1'b0, cur_off} + 1'b1;
  assign slot_hit = slot_vld && (bus_addr[SLOT_MSB:SLOT_LSB] == slot_q)
                    && (bus_addr[AW-1:SLOT_MSB+1] == '0);
  assign hit      = (st == S_IDLE) && strb && a32_cyc && (cont || slot_hit);
  assign bad      = !word_cyc
                    || (!cont && bus_addr[1:0] != 2'b00)
                    || (32'(cur_reg) >= LIVE_CNT)
                    || (blk_cyc && 32'(cur_reg) == CSR_REG)
                    || (wr && 32'(cur_reg) == ID_REG)
                    || (cont && (bst_bad || bst_wrap));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wr_q     <= 1'b0;
      ack_q    <= 1'b0;
      berr_q   <= 1'b0;
      reg_q    <= '0;
      off_q    <= '0;
      rdata_q  <= '0;
      bst_act  <= 1'b0;
      bst_bad  <= 1'b0;
      bst_wrap <= 1'b0;
      bst_reg  <= '0;
      bst_off  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (!blk_cyc) begin
            bst_act  <= 1'b0;
            bst_bad  <= 1'b0;
            bst_wrap <= 1'b0;
          end
          if (hit) begin
            wr_q  <= wr;
            reg_q <= cur_reg;
            off_q <= cur_off;
            if (blk_cyc) begin
              bst_act  <= 1'b1;
              bst_reg  <= cur_reg;
              bst_off  <= nxt_off[WORD_W-1:0];
              bst_wrap <= nxt_off[WORD_W] || (cont && bst_wrap);
              bst_bad  <= bad;
            end
            if (bad) begin
              berr_q <= 1'b1;
              st     <= S_DONE;
            end else begin
              st <= S_ACC;
            end
          end
        end
        S_ACC: begin
          rdata_q <= region_rdata[reg_q*DW +: DW];
          ack_q   <= 1'b1;
          st      <= S_DONE;
        end
        default: begin
          if (!strb) begin
            ack_q  <= 1'b0;
            berr_q <= 1'b0;
            st     <= S_IDLE;
          end
        end
      endcase
    end
  end

  for (genvar i = 0; i < REG_CNT; i++) begin : g_sel
    assign region_sel[i] = (st == S_ACC) && (32'(reg_q) == i);
  end

  assign reg_addr  = {off_q, 2'b00};
  assign reg_wr    = (st == S_ACC) && wr_q;
  assign reg_wdata = bus_wdata;
  assign ack       = ack_q;
  assign berr      = berr_q;
  assign rdata     = ack_q ? rdata_q : '0;
endmodule

// File: rtl/slot_bus_decoder_chk.sv
module slot_bus_decoder_chk #(
  parameter int REG_CNT = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               strb,
  input logic               blk_cyc,
  input logic [REG_CNT-1:0] region_sel,
  input logic               reg_wr,
  input logic               ack,
  input logic               berr
);
  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_sel));
  // R4
  sel_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|region_sel) |=> ack);
  // R4
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && strb) |=> ack);
  // R4
  resp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack || berr) && !strb) |=> !(ack || berr));
  // R5
  ack_berr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && berr));
  // R6
  reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region_sel[7:6] == 2'b00);
  // R7
  id_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region_sel[0] |-> !reg_wr);
  // R8
  csr_no_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    region_sel[1] |-> !blk_cyc);
endmodule

bind slot_bus_decoder slot_bus_decoder_chk u_chk (.*);

// File: tb/slot_bus_decoder_bench.sv
module slot_bus_decoder_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   slot_id = 6'd17;
  logic         strb = 1'b0, a32_cyc = 1'b0, word_cyc = 1'b0, blk_cyc = 1'b0, wr = 1'b0;
  logic [31:0]  bus_addr = '0, bus_wdata = '0;
  logic [255:0] region_rdata;
  logic [7:0]   region_sel;
  logic [12:0]  reg_addr;
  logic         reg_wr, ack, berr;
  logic [31:0]  reg_wdata, rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slot_bus_decoder u_slot_bus_decoder (.*);

  for (genvar i = 0; i < 8; i++) begin : g_rd
    assign region_rdata[i*32 +: 32] = {8'(i), 11'b0, reg_addr};
  end

  int          o_kind, o_lat, o_selcnt;
  logic [7:0]  o_sel;
  logic [12:0] o_addr;
  logic        o_wr, o_wd_ok, o_hold_ok, o_rel_ok;
  logic [31:0] o_rdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic beat(input logic [31:0] a, input logic w, input logic s32, input logic wd,
                      input logic bk, input int hold, input logic keep);
    o_kind = 0; o_lat = 0; o_selcnt = 0; o_sel = '0; o_addr = '0; o_wr = 0;
    o_wd_ok = 1; o_hold_ok = 1; o_rel_ok = 1; o_rdata = '0;
    @(negedge clk);
    bus_addr = a; wr = w; a32_cyc = s32; word_cyc = wd; blk_cyc = bk;
    bus_wdata = a ^ 32'h5A5A_0F0F; strb = 1'b1;
    for (int n = 1; n <= 6 && o_kind == 0; n++) begin
      @(negedge clk);
      if (region_sel != '0) begin
        o_selcnt++; o_sel = region_sel; o_addr = reg_addr; o_wr = reg_wr;
        o_wd_ok = (reg_wdata == bus_wdata);
      end
      if (ack) begin o_kind = 1; o_lat = n; o_rdata = rdata; end
      else if (berr) begin o_kind = 2; o_lat = n; end
    end
    for (int n = 0; n < hold; n++) begin
      @(negedge clk);
      if (!(ack || berr) || region_sel != '0) o_hold_ok = 0;
    end
    strb = 1'b0;
    @(negedge clk);
    if (o_kind != 0 && (ack || berr)) o_rel_ok = 0;
    if (!keep) blk_cyc = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_ack(input string tag, input logic [31:0] a, input int rg,
                            input logic [12:0] off, input logic w);
    chk(o_kind == 1, {tag, " ack"}, o_kind, 1);
    chk(o_sel == 8'(1 << rg) && o_selcnt == 1, {tag, " select"}, o_sel, 8'(1 << rg));
    chk(o_addr == off, {tag, " offset"}, o_addr, off);
    chk(o_wr == w && o_wd_ok, {tag, " write strobe"}, o_wr, w);
    chk(o_lat == 2, {tag, " latency"}, o_lat, 2);
    chk(o_rel_ok, {tag, " release"}, o_rel_ok, 1);
    if (!w) chk(o_rdata == {8'(rg), 11'b0, off}, {tag, " rdata"}, o_rdata, {8'(rg), 11'b0, off});
    if (a == 32'hFFFF_FFFF) chk(0, tag, 0, 0);
  endtask

  task automatic expect_err(input string tag);
    chk(o_kind == 2 && o_lat == 1, {tag, " berr"}, o_kind, 2);
    chk(o_sel == '0, {tag, " no select"}, o_sel, 0);
    chk(o_rel_ok, {tag, " release"}, o_rel_ok, 1);
  endtask

  task automatic expect_none(input string tag);
    chk(o_kind == 0, {tag, " silent"}, o_kind, 0);
    chk(o_sel == '0, {tag, " no select"}, o_sel, 0);
  endtask

  // {addr, wr, a32, word, blk, kind(0 none,1 ack,2 berr), region, req}
  localparam logic [44:0] VEC [17] = '{
    {32'h0011_0000, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 3'd0, 4'd3},  // R3 R7 read ID
    {32'h0011_2004, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 3'd1, 4'd3},  // R3
    {32'h0011_4010, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 3'd2, 4'd3},  // R3
    {32'h0011_7FFC, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 3'd3, 4'd3},  // R3 last word
    {32'h0011_8008, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 3'd4, 4'd3},  // R3
    {32'h0011_A000, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 3'd5, 4'd3},  // R3
    {32'h0011_C000, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 3'd0, 4'd6},  // R6
    {32'h0011_E004, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 3'd0, 4'd6},  // R6
    {32'h0011_0000, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 3'd0, 4'd7},  // R7
    {32'h0011_2000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0, 4'd2},  // R2
    {32'h0012_2000, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 3'd0, 4'd1},  // R1 slot
    {32'h8011_2000, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 3'd0, 4'd1},  // R1 upper bits
    {32'h0011_4000, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 3'd0, 4'd5},  // R5 narrow
    {32'h0011_4002, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 3'd0, 4'd5},  // R5 misaligned
    {32'h0011_2000, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 3'd0, 4'd8},  // R8 block to CSR
    {32'h0011_4000, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 3'd2, 4'd8},  // R8 block elsewhere
    {32'h0011_2008, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 3'd1, 4'd8}   // R8 single CSR write
  };

  initial begin
    repeat (3) @(negedge clk);
    // R12
    chk(region_sel == '0 && !reg_wr, "R12 selects in reset", region_sel, 0);
    chk(!ack && !berr && rdata == '0, "R12 response in reset", {ack, berr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    slot_id = 6'd5;
    chk(region_sel == '0 && !ack && !berr, "R12 idle after reset", {ack, berr}, 0);

    foreach (VEC[i]) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      beat(VEC[i][44:13], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], 0, 1'b0);
      case (VEC[i][8:7])
        2'd1: expect_ack(tag, VEC[i][44:13], int'(VEC[i][6:4]),
                         VEC[i][25:13] & 13'h1FFC, VEC[i][12]);
        2'd2: expect_err(tag);
        default: expect_none(tag);
      endcase
    end

    // R11 window stays at the strap sampled after reset
    beat(32'h0005_2000, 0, 1, 1, 0, 0, 0);
    expect_none("R11 new strap");
    beat(32'h0011_2000, 0, 1, 1, 0, 0, 0);
    expect_ack("R11 old strap", 32'h0011_2000, 1, 13'h0000, 0);

    // R4 hold while strobe stays high
    beat(32'h0011_6000, 0, 1, 1, 0, 3, 0);
    expect_ack("R4 held", 32'h0011_6000, 3, 13'h0000, 0);
    chk(o_hold_ok, "R4 ack held", o_hold_ok, 1);

    // R9 burst ignores bus address after first beat
    beat(32'h0011_4100, 0, 1, 1, 1, 0, 1);
    expect_ack("R9 beat0", 0, 2, 13'h0100, 0);
    beat(32'h0033_0000, 0, 1, 1, 1, 0, 1);
    expect_ack("R9 beat1", 0, 2, 13'h0104, 0);
    beat(32'h0000_0002, 0, 1, 1, 1, 0, 0);
    expect_ack("R9 beat2", 0, 2, 13'h0108, 0);
    beat(32'h0011_8000, 1, 1, 1, 1, 0, 1);
    expect_ack("R9 wbeat0", 0, 4, 13'h0000, 1);
    beat(32'h0011_0000, 1, 1, 1, 1, 0, 0);
    expect_ack("R9 wbeat1", 0, 4, 13'h0004, 1);

    // R10 burst cut at region end
    beat(32'h0011_5FF8, 1, 1, 1, 1, 0, 1);
    expect_ack("R10 beat0", 0, 2, 13'h1FF8, 1);
    beat(32'h0000_0000, 1, 1, 1, 1, 0, 1);
    expect_ack("R10 beat1", 0, 2, 13'h1FFC, 1);
    beat(32'h0000_0000, 1, 1, 1, 1, 0, 1);
    expect_err("R10 beat2");
    beat(32'h0011_4000, 1, 1, 1, 1, 0, 0);
    expect_err("R10 beat3");
    beat(32'h0011_4000, 0, 1, 1, 0, 0, 0);
    expect_ack("R10 after burst", 0, 2, 13'h0000, 0);

    // R8 later beats of a refused control burst
    beat(32'h0011_2000, 0, 1, 1, 1, 0, 1);
    expect_err("R8 csr beat0");
    beat(32'h0011_4000, 0, 1, 1, 1, 0, 0);
    expect_err("R8 csr beat1");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule